// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Cache

This block lets a processor read serial flash as if it were ordinary memory. A 32-bit read arrives on a request/ready port. If the address falls inside the window the block last fetched, the buffered word comes back one cycle later. Otherwise the block runs a complete flash read command over a byte-wide SPI transfer engine and fills a 1 KB line buffer. It then releases the device and answers the read from the new line.

The command is built from a configuration register that resets to `0x03A002EB` and can be rewritten through a write port. The register holds:

- the instruction byte in bits 7:0,
- an enable for an optional mode byte in bit 25,
- the mode byte value in bits 23:16,
- a dummy byte count in bits 10:8.

The flash address is the bus address shifted right by `STRIPE_LOG2` (the log2 of the number of active buses). The bits of that flash address above bit 23 pick which chip select goes low.

The buffered window is anchored at the exact address that missed, with no alignment to the line size. After a miss at address B, reads from B up to B+1020 hit. Serial clocking and multi-lane I/O belong to the transfer engine, not to this block.

Top module: `flash_window_cache`

## Requirements
- R1: After reset, `rd_ready` is 0, every `spi_cs_n` bit is 1 and `xfer_valid` is 0. The configuration holds `0x03A002EB`, so the first refill frame is: instruction 0xEB, then the address, then mode byte 0xA0, then two dummy bytes.
- R2: No line is valid after reset, so the first read always runs a refill.
- R3: Let B be the base of the current line. A read with B <= addr <= B+1020 is a hit. A hit raises `rd_ready` on the first clock edge after the request is accepted, starts no SPI transfer, and returns word (addr-B)/4 of the line.
- R4: During a refill, exactly one chip select is low. It is bit `(addr >> STRIPE_LOG2) >> 24` of `spi_cs_n`, and it stays low for every byte of the refill.
- R5: The frame starts with the instruction byte `cfg[7:0]`, followed by the 24-bit flash address, most significant byte first.
- R6: When `cfg[25]` is 1, the byte `cfg[23:16]` follows the address. When `cfg[25]` is 0, no mode byte is sent.
- R7: Next come `cfg[10:8]` dummy bytes of value 0x00. Bytes received during the whole command part are discarded.
- R8: The data phase sends 1024 bytes of 0x00. The received bytes are packed little-endian: the first byte of each group of four goes into bits 7:0 of the line word.
- R9: At the end of a refill, chip select is released before `rd_ready` rises, and the line base becomes the missing address. Reads at base-4 and at base+1024 therefore miss.
- R10: `rd_ready` is a single-cycle pulse. It stays low through the whole refill, and only one request is handled at a time.
- R11: A `cfg_we` pulse loads `cfg_wdata`, and the next refill uses the new instruction, mode and dummy settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| rd_req | input | 1 | Read request; held until `rd_ready` |
| rd_addr | input | ADDR_W | Word-aligned byte address of the read |
| rd_ready | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | 32 | Read data |
| spi_cs_n | output | NUM_DEV | Active-low chip selects |
| xfer_valid | output | 1 | A byte transfer is pending |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Engine pulse: the pending byte has completed |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |

## Verification
The assertions take for granted that the transfer engine pulses `xfer_done` for a single cycle, and only while `xfer_valid` is high. They also assume the requester holds `rd_req` and an aligned `rd_addr` until it sees `rd_ready`, and does not write the configuration during a refill. The bench's engine model answers each pending byte after a latency of 0 or 2 cycles, then drops `xfer_done` in the next cycle. The bench issues one read at a time and writes the configuration only between reads. Received bytes are a function of the position within each chip-select session, which makes any discarded or misplaced byte show up in the returned words.

// File: rtl/flash_window_cache.sv
module flash_window_cache #(
  parameter int          NUM_DEV     = 2,
  parameter int          STRIPE_LOG2 = 0,
  parameter int          ADDR_W      = 25,
  parameter int          DEV_ADDR_W  = 24,
  parameter int          LINE_BYTES  = 1024,
  parameter logic [31:0] CFG_RESET   = 32'h03A0_02EB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic               rd_req,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_ready,
  output logic [31:0]        rd_data,
  output logic [NUM_DEV-1:0] spi_cs_n,
  output logic               xfer_valid,
  output logic [7:0]         xfer_tx,
  input  logic               xfer_done,
  input  logic [7:0]         xfer_rx
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int IW    = $clog2(WORDS);
  localparam int BCW   = $clog2(LINE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_CMD, S_DATA, S_REL, S_ANS} st_t;
  st_t state;

  logic [31:0]     cfg_q, base_q, req_q;
  logic            base_ok;
  logic [3:0]      cidx;
  logic [BCW-1:0]  bcnt;
  logic [31:0]     word_sh;
  logic [31:0]     mem [WORDS];

  logic [31:0] addr32, fa32, off, req_fa;
  logic        hit, accept;
  logic [IW-1:0] hit_idx;
  logic [3:0]  frame_end;
  logic [7:0]  cmd_tx;
  logic [31:0] word_nx;
  logic        cfg_unused;

  assign addr32    = 32'(rd_addr);
  assign fa32      = addr32 >> STRIPE_LOG2;
  assign req_fa    = req_q >> STRIPE_LOG2;
  assign off       = addr32 - base_q;
  assign hit       = base_ok && (addr32 >= base_q) && (off <= 32'(LINE_BYTES - 4));
  assign hit_idx   = off[IW+1:2];
  assign accept    = (state == S_IDLE) && rd_req && !rd_ready;
  assign frame_end = 4'd3 + 4'(cfg_q[25]) + 4'(cfg_q[10:8]);
  assign word_nx   = {xfer_rx, word_sh[31:8]};
  assign cfg_unused = ^{cfg_q[31:26], cfg_q[24], cfg_q[15:11], off[1:0], off[31:IW+2],
                        req_fa[31:24], fa32[DEV_ADDR_W-1:0]};

  always_comb begin
    case (cidx)
      4'd0:    cmd_tx = cfg_q[7:0];
      4'd1:    cmd_tx = req_fa[23:16];
      4'd2:    cmd_tx = req_fa[15:8];
      4'd3:    cmd_tx = req_fa[7:0];
      4'd4:    cmd_tx = cfg_q[25] ? cfg_q[23:16] : 8'h00;
      default: cmd_tx = 8'h00;
    endcase
  end

  assign xfer_valid = (state == S_CMD) || (state == S_DATA);
  assign xfer_tx    = (state == S_CMD) ? cmd_tx : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg_q    <= CFG_RESET;
      base_q   <= '0;
      base_ok  <= 1'b0;
      req_q    <= '0;
      cidx     <= '0;
      bcnt     <= '0;
      word_sh  <= '0;
      rd_ready <= 1'b0;
      spi_cs_n <= '1;
    end else begin
      rd_ready <= 1'b0;
      if (cfg_we) cfg_q <= cfg_wdata;
      case (state)
        S_IDLE: if (accept) begin
          if (hit) rd_ready <= 1'b1;
          else begin
            req_q    <= addr32;
            spi_cs_n <= ~(NUM_DEV'(1) << (fa32 >> DEV_ADDR_W));
            state    <= S_SEL;
          end
        end
        S_SEL: begin
          cidx  <= '0;
          state <= S_CMD;
        end
        S_CMD: if (xfer_done) begin
          if (cidx == frame_end) begin
            bcnt  <= '0;
            state <= S_DATA;
          end else cidx <= cidx + 4'd1;
        end
        S_DATA: if (xfer_done) begin
          word_sh <= word_nx;
          bcnt    <= bcnt + BCW'(1);
          if (bcnt == BCW'(LINE_BYTES - 1)) state <= S_REL;
        end
        S_REL: begin
          spi_cs_n <= '1;
          base_q   <= req_q;
          base_ok  <= 1'b1;
          state    <= S_ANS;
        end
        S_ANS: begin
          rd_ready <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_DATA && xfer_done && bcnt[1:0] == 2'd3) mem[bcnt[BCW-1:2]] <= word_nx;
    if (accept && hit) rd_data <= mem[hit_idx];
    else if (state == S_ANS) rd_data <= mem[IW'(0)];
  end

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  a_r4_cs_during_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !(&spi_cs_n));
  a_r5_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_tx)));
  a_r9_released_at_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (&spi_cs_n));
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
  a_r10_quiet_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !rd_ready);
endmodule

// File: tb/test_flash_window_cache.sv
module test_flash_window_cache;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = 0;
  logic        rd_req = 0;
  logic [24:0] rd_addr = 0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic [1:0]  spi_cs_n;
  logic        xfer_valid, xfer_done;
  logic [7:0]  xfer_tx, xfer_rx;

  always #5 clk = ~clk;

  flash_window_cache i_flash_window_cache (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .xfer_valid(xfer_valid), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx));

  int n_cmp = 0, n_bad = 0;
  int sess = 0, pos = 0, wait_cnt = 0;
  bit prev_idle = 1;
  logic [7:0]  exp_q[$];
  string       exp_tag[$];
  logic [1:0]  exp_cs = 2'b11;
  logic [31:0] cfg_m = 32'h03A0_02EB;
  logic [31:0] base_m = 0;
  bit          valid_m = 0;
  int          line_sess = 0, line_flen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_of(input int s, input int p);
    return 8'((p * 7 + s * 29 + (p / 256) * 3 + 5) & 255);
  endfunction

  initial begin
    xfer_done = 0;
    xfer_rx   = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        xfer_done = 0;
        wait_cnt  = 0;
      end else begin
        if (prev_idle && !(&spi_cs_n)) begin
          sess++;
          pos = 0;
        end
        prev_idle = &spi_cs_n;
        if (xfer_done) xfer_done = 0;
        else if (xfer_valid) begin
          if (wait_cnt >= ((pos % 3 == 1) ? 2 : 0)) begin
            if (pos < exp_q.size()) begin
              chk(xfer_tx == exp_q[pos], exp_tag[pos], $sformatf("tx byte %0d", pos),
                  xfer_tx, exp_q[pos]);
              chk(spi_cs_n == exp_cs, "R4", "chip select", spi_cs_n, exp_cs);
            end else chk(0, "R8", "byte beyond frame", pos, exp_q.size());
            xfer_rx   = rx_of(sess, pos);
            xfer_done = 1;
            pos++;
            wait_cnt = 0;
          end else wait_cnt++;
        end
      end
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    cfg_m = v;
  endtask

  task automatic do_read(input logic [24:0] a, input string first_tag);
    bit miss;
    int cyc, idx, p0, sess0;
    logic [31:0] fa, w;
    sess0 = sess;
    miss = !(valid_m && {7'd0, a} >= base_m && ({7'd0, a} - base_m) <= 32'd1020);
    if (miss) begin
      fa = {7'd0, a};
      exp_q.delete();
      exp_tag.delete();
      exp_q.push_back(cfg_m[7:0]);    exp_tag.push_back(first_tag);
      exp_q.push_back(fa[23:16]);     exp_tag.push_back("R5");
      exp_q.push_back(fa[15:8]);      exp_tag.push_back("R5");
      exp_q.push_back(fa[7:0]);       exp_tag.push_back("R5");
      if (cfg_m[25]) begin
        exp_q.push_back(cfg_m[23:16]); exp_tag.push_back("R6");
      end
      for (int i = 0; i < int'(cfg_m[10:8]); i++) begin
        exp_q.push_back(8'h00); exp_tag.push_back("R7");
      end
      line_flen = exp_q.size();
      for (int i = 0; i < 1024; i++) begin
        exp_q.push_back(8'h00); exp_tag.push_back("R8");
      end
      exp_cs    = ~(2'b01 << fa[24]);
      line_sess = sess + 1;
      base_m    = fa;
      valid_m   = 1;
    end
    @(negedge clk);
    rd_addr = a;
    rd_req  = 1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rd_ready && cyc < 6000);
    rd_req = 0;
    if (!rd_ready) begin
      chk(0, "R10", "no ready (timeout)", cyc, 0);
      return;
    end
    idx = int'(({7'd0, a} - base_m) / 4);
    p0  = line_flen + 4 * idx;
    w = {rx_of(line_sess, p0 + 3), rx_of(line_sess, p0 + 2),
         rx_of(line_sess, p0 + 1), rx_of(line_sess, p0)};
    chk(rd_data == w, miss ? "R8" : "R3", $sformatf("data @%0h", a), rd_data, w);
    if (miss) begin
      chk(pos == exp_q.size(), "R8", "bytes in refill", pos, exp_q.size());
      chk(sess == sess0 + 1, "R9", "one refill session", sess, sess0 + 1);
      chk(&spi_cs_n, "R9", "cs released at answer", spi_cs_n, 2'b11);
    end else begin
      chk(cyc == 1, "R3", "hit latency", cyc, 1);
      chk(sess == sess0, "R3", "no transfer on hit", sess, sess0);
    end
    @(negedge clk);
    chk(!rd_ready, "R10", "ready single pulse", rd_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_ready == 0, "R1", "reset rd_ready", rd_ready, 0);
    chk(spi_cs_n == 2'b11, "R1", "reset cs", spi_cs_n, 2'b11);
    chk(xfer_valid == 0, "R1", "reset xfer_valid", xfer_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    do_read(25'h000_1000, "R1");
    chk(sess == 1, "R2", "first read refilled", sess, 1);
    do_read(25'h000_1000, "R5");
    do_read(25'h000_1004, "R5");
    do_read(25'h000_13FC, "R5");
    do_read(25'h000_1200, "R5");
    do_read(25'h000_1400, "R5");
    do_read(25'h000_13FC, "R5");
    do_read(25'h100_2008, "R5");
    do_read(25'h100_2404, "R5");
    do_read(25'h100_2408, "R5");
    write_cfg(32'h0000_0503);
    do_read(25'h000_3000, "R11");
    do_read(25'h000_33F0, "R11");
    write_cfg(32'h0255_070B);
    do_read(25'h1FF_FC00, "R11");
    do_read(25'h1FF_FFFC, "R11");
    write_cfg(32'h0000_00BB);
    do_read(25'h080_0000, "R11");
    do_read(25'h080_0100, "R11");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule